// File: doc/BRIEF.md
# Multi-Rate Soft-Symbol Depuncturer

This block restores the mother rate-1/2 structure of a punctured convolutional code stream ahead of branch-metric computation. It accepts one soft symbol per transfer from a punctured stream at rate 1/2, 2/3, 3/4, 5/6 or 7/8. It emits one X/Y pair per transfer. Any position that puncturing removed is filled with soft value 0, and an erasure flag is raised beside it so the metric stage can ignore it.

The code rate comes from a plain control input and may change while the block runs. The keep/delete pattern for the active rate is held in a circular register that moves one step per emitted pair. A rate change takes effect at the next pair boundary, and the new pattern then starts at phase 0.

Both stream sides use valid/ready. An input symbol transfers when `in_valid` and `in_ready` are both high at a rising clock edge; a pair transfers the same way on `out_valid`/`out_ready`. `in_ready` drops when accepting the offered symbol would complete a pair while the output register is full and not draining. While stalled, the output pair holds steady.

Top module: `depunct_core`

## Requirements
- R1: During and right after reset, `out_valid` is 0. The active rate is 1/2, so with `rate_sel`=0 the block offers `in_ready`=1 at once.
- R2: At rate 1/2 (`rate_sel`=0), each pair takes two consecutive input symbols, X first and then Y, with both erasure flags 0.
- R3: At rate 2/3 (`rate_sel`=1), the pattern is two pairs long. X is kept in phase 0 only; Y is kept in both phases.
- R4: At rate 3/4 (`rate_sel`=2), the pattern is three pairs long. X is kept in phases 0 and 2, and Y in phases 0 and 1, giving the input order X1 Y1 Y2 X3.
- R5: At rate 5/6 (`rate_sel`=3), the pattern is five pairs long. X is kept in phases 0, 2 and 4, and Y in phases 0, 1 and 3.
- R6: At rate 7/8 (`rate_sel`=4), the pattern is seven pairs long. X is kept in phases 0, 4 and 6, and Y in phases 0, 1, 2, 3 and 5, giving the input order X1 Y1 Y2 Y3 Y4 X5 Y6 X7.
- R7: An erased position carries value 0 with its flag at 1. A received position has its flag at 0. No pair has both positions erased.
- R8: `rate_sel` codes 5, 6 and 7 behave exactly like code 0 (rate 1/2).
- R9: If `rate_sel` changes mid-pair, the current pair completes under the old pattern. The next cycle has `in_ready`=0 while the new pattern loads. The new rate then begins at phase 0.
- R10: While `out_valid`=1 and `out_ready`=0, the output pair and flags hold steady. No symbol is accepted that would complete another pair. The output register may drain and reload in the same cycle.
- R11: Cycles with `in_valid`=0 leave the pattern phase and the partly built pair unchanged.
- R12: The pattern wraps circularly: after the last phase of a rate, the next pair uses phase 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Code rate select: 0=1/2, 1=2/3, 2=3/4, 3=5/6, 4=7/8, other=1/2 |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Input symbol can be taken this cycle |
| in_sym | input | SYM_W | Soft input symbol |
| out_valid | output | 1 | Output pair held |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| out_x | output | SYM_W | X soft value (0 when erased) |
| out_x_erase | output | 1 | X position was inserted |
| out_y | output | SYM_W | Y soft value (0 when erased) |
| out_y_erase | output | 1 | Y position was inserted |

## Verification
Two events can fall in one cycle.

The first pairing is a drain of the held output pair together with the completion of a new pair. The bench stalls the output until `in_ready` falls with half a pair built. It then raises `out_ready` together with the missing symbol and expects the new pair in the register one cycle later, with nothing lost or duplicated.

The second pairing is a rate change together with the symbol that completes a pair. The bench changes `rate_sel` in the cycle the Y symbol is offered. It then checks that this pair carries the old rate's flags, that exactly one reload cycle with `in_ready` low follows, and that the new rate's erasures begin at phase 0.

// File: rtl/depunct_pkg.sv
package depunct_pkg;

  // Longest puncturing period among the supported rates (pairs)
  localparam int MAX_PERIOD = 7;
  localparam int PHASE_W    = $clog2(MAX_PERIOD + 1);
  localparam int RATE_W     = 3;

  typedef logic [RATE_W-1:0] rate_code_t;

  localparam rate_code_t RATE_1_2 = 3'd0;
  localparam rate_code_t RATE_2_3 = 3'd1;
  localparam rate_code_t RATE_3_4 = 3'd2;
  localparam rate_code_t RATE_5_6 = 3'd3;
  localparam rate_code_t RATE_7_8 = 3'd4;

  // Keep masks: bit p set means position kept in phase p
  typedef struct packed {
    logic [MAX_PERIOD-1:0] x_keep;
    logic [MAX_PERIOD-1:0] y_keep;
    logic [PHASE_W-1:0]    period;
  } punct_pat_t;

  // Unused codes fall back to the mother rate
  function automatic rate_code_t rate_norm(input rate_code_t code);
    return (code > RATE_7_8) ? RATE_1_2 : code;
  endfunction

endpackage

// File: rtl/dp_pattern_table.sv
module dp_pattern_table
  import depunct_pkg::*;
(
  input  rate_code_t rate,
  output punct_pat_t pat
);

  always_comb begin
    pat = '0;
    unique case (rate)
      RATE_2_3: begin
        pat.x_keep = 7'b0000001;
        pat.y_keep = 7'b0000011;
        pat.period = PHASE_W'(2);
      end
      RATE_3_4: begin
        pat.x_keep = 7'b0000101;
        pat.y_keep = 7'b0000011;
        pat.period = PHASE_W'(3);
      end
      RATE_5_6: begin
        pat.x_keep = 7'b0010101;
        pat.y_keep = 7'b0001011;
        pat.period = PHASE_W'(5);
      end
      RATE_7_8: begin
        pat.x_keep = 7'b1010001;
        pat.y_keep = 7'b0101111;
        pat.period = PHASE_W'(7);
      end
      default: begin
        pat.x_keep = 7'b0000001;
        pat.y_keep = 7'b0000001;
        pat.period = PHASE_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/dp_pattern_ring.sv
module dp_pattern_ring
  import depunct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rate_code_t rate_sel,
  input  logic       at_boundary,
  input  logic       advance,
  output logic       keep_x,
  output logic       keep_y,
  output logic       reload_pending
);

  rate_code_t            req_rate;
  rate_code_t            active_rate;
  punct_pat_t            new_pat;
  logic [MAX_PERIOD-1:0] x_ring, y_ring;
  logic [MAX_PERIOD-1:0] x_rot, y_rot;
  logic [PHASE_W-1:0]    period;
  logic [PHASE_W-1:0]    phase;
  logic [PHASE_W-1:0]    last_phase;
  logic                  reload;

  assign req_rate       = rate_norm(rate_sel);
  assign reload_pending = (req_rate != active_rate);
  assign reload         = reload_pending && at_boundary;
  assign last_phase     = period - PHASE_W'(1);
  assign keep_x         = x_ring[0];
  assign keep_y         = y_ring[0];

  dp_pattern_table u_table (
    .rate (req_rate),
    .pat  (new_pat)
  );

  // Circular rotation over the active period: bit 0 re-enters at period-1
  for (genvar i = 0; i < MAX_PERIOD; i++) begin : g_rot
    if (i == MAX_PERIOD - 1) begin : g_top
      assign x_rot[i] = (last_phase == PHASE_W'(i)) ? x_ring[0] : 1'b0;
      assign y_rot[i] = (last_phase == PHASE_W'(i)) ? y_ring[0] : 1'b0;
    end else begin : g_mid
      assign x_rot[i] = (last_phase == PHASE_W'(i)) ? x_ring[0] : x_ring[i+1];
      assign y_rot[i] = (last_phase == PHASE_W'(i)) ? y_ring[0] : y_ring[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_rate <= RATE_1_2;
      x_ring      <= MAX_PERIOD'(1);
      y_ring      <= MAX_PERIOD'(1);
      period      <= PHASE_W'(1);
      phase       <= '0;
    end else if (reload) begin
      active_rate <= req_rate;
      x_ring      <= new_pat.x_keep;
      y_ring      <= new_pat.y_keep;
      period      <= new_pat.period;
      phase       <= '0;
    end else if (advance) begin
      x_ring <= x_rot;
      y_ring <= y_rot;
      phase  <= (phase == last_phase) ? '0 : phase + PHASE_W'(1);
    end
  end

  // R12: phase stays inside the active period
  p_phase_in_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    phase < period);

  // R12: stepping past the last phase returns to phase 0
  p_wrap_to_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload && phase == last_phase) |=> (phase == '0));

  // R9: the active rate only changes after a pair boundary
  p_reload_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_rate) |-> $past(at_boundary));

  // R7: every phase keeps at least one of the two positions
  p_no_empty_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_x || keep_y));

endmodule

// File: rtl/dp_pair_builder.sv
module dp_pair_builder #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             keep_x,
  input  logic             keep_y,
  input  logic             hold_off,
  output logic             at_boundary,
  output logic             advance,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_x,
  output logic             out_x_erase,
  output logic [SYM_W-1:0] out_y,
  output logic             out_y_erase
);

  localparam logic [SYM_W-1:0] FILL = '0;

  typedef enum logic {SLOT_X = 1'b0, SLOT_Y = 1'b1} slot_e;

  slot_e            slot;
  logic [SYM_W-1:0] x_hold;
  logic             out_free;
  logic             completes;
  logic             take;
  logic             emit;
  logic [SYM_W-1:0] nx_x, nx_y;
  logic             nx_xe, nx_ye;

  assign at_boundary = (slot == SLOT_X);
  assign out_free    = !out_valid || out_ready;
  // Would the offered symbol close the current pair?
  assign completes   = !at_boundary || !keep_x || !keep_y;
  assign in_ready    = !(at_boundary && hold_off) && (!completes || out_free);
  assign take        = in_valid && in_ready;
  assign emit        = take && completes;
  assign advance     = emit;

  always_comb begin
    nx_x  = x_hold;
    nx_xe = 1'b0;
    nx_y  = in_sym;
    nx_ye = 1'b0;
    if (at_boundary) begin
      if (keep_x) begin
        nx_x  = in_sym;
        nx_y  = FILL;
        nx_ye = 1'b1;
      end else begin
        nx_x  = FILL;
        nx_xe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= SLOT_X;
      x_hold <= '0;
    end else if (take) begin
      if (at_boundary && keep_x && keep_y) begin
        slot   <= SLOT_Y;
        x_hold <= in_sym;
      end else begin
        slot <= SLOT_X;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_x       <= '0;
      out_x_erase <= 1'b0;
      out_y       <= '0;
      out_y_erase <= 1'b0;
    end else if (emit) begin
      out_valid   <= 1'b1;
      out_x       <= nx_x;
      out_x_erase <= nx_xe;
      out_y       <= nx_y;
      out_y_erase <= nx_ye;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled pair holds its contents
  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_x_erase) && $stable(out_y_erase)));

  // R7: never both positions erased
  p_single_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_x_erase && out_y_erase));

  // R7: erased positions carry the zero filler
  p_fill_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((!out_x_erase || out_x == FILL) && (!out_y_erase || out_y == FILL)));

  // R9: no symbol accepted while a rate reload waits at a boundary
  p_no_take_on_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_off && at_boundary) |-> !in_ready);

  // R11: an idle input leaves the half-built pair untouched
  p_idle_keeps_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(slot) && $stable(x_hold));

endmodule

// File: rtl/depunct_core.sv
module depunct_core
  import depunct_pkg::*;
#(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_sym,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_x,
  output logic             out_x_erase,
  output logic [SYM_W-1:0] out_y,
  output logic             out_y_erase
);

  logic keep_x, keep_y, reload_pending, at_boundary, advance;

  dp_pattern_ring u_ring (
    .clk            (clk),
    .rst_n          (rst_n),
    .rate_sel       (rate_code_t'(rate_sel)),
    .at_boundary    (at_boundary),
    .advance        (advance),
    .keep_x         (keep_x),
    .keep_y         (keep_y),
    .reload_pending (reload_pending)
  );

  dp_pair_builder #(.SYM_W(SYM_W)) u_build (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sym      (in_sym),
    .keep_x      (keep_x),
    .keep_y      (keep_y),
    .hold_off    (reload_pending),
    .at_boundary (at_boundary),
    .advance     (advance),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_x       (out_x),
    .out_x_erase (out_x_erase),
    .out_y       (out_y),
    .out_y_erase (out_y_erase)
  );

  // R2: every completed pair consumed an input symbol in that cycle
  p_pair_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (in_valid && in_ready));

endmodule

// File: tb/depunct_core_test.sv
module depunct_core_test;

  localparam int SYM_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       rate_sel = 3'd0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [SYM_W-1:0] in_sym = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [SYM_W-1:0] out_x, out_y;
  logic             out_x_erase, out_y_erase;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  depunct_core #(.SYM_W(SYM_W)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_x_erase(out_x_erase),
    .out_y(out_y), .out_y_erase(out_y_erase)
  );

  // Row: rate code, pair count, X/Y erasure masks (bit k = pair k), mode
  // mode 0: free flow, 1: input gaps, 2: output stalls
  typedef struct packed {
    logic [2:0]  rate;
    logic [4:0]  npairs;
    logic [15:0] xe;
    logic [15:0] ye;
    logic [1:0]  mode;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 5'd4,  16'h0000, 16'h0000, 2'd0},  // R2
    '{3'd1, 5'd4,  16'h000A, 16'h0000, 2'd0},  // R3
    '{3'd2, 5'd6,  16'h0012, 16'h0024, 2'd0},  // R4 R12
    '{3'd3, 5'd10, 16'h014A, 16'h0294, 2'd0},  // R5 R12
    '{3'd4, 5'd14, 16'h172E, 16'h2850, 2'd0},  // R6 R12
    '{3'd6, 5'd3,  16'h0000, 16'h0000, 2'd0},  // R8
    '{3'd7, 5'd3,  16'h0000, 16'h0000, 2'd0},  // R8
    '{3'd4, 5'd7,  16'h002E, 16'h0050, 2'd1},  // R11
    '{3'd3, 5'd5,  16'h000A, 16'h0014, 2'd2},  // R10
    '{3'd2, 5'd3,  16'h0002, 16'h0004, 2'd2}   // R10
  };

  function automatic string row_req(input int r);
    case (r)
      0: return "R2";
      1: return "R3";
      2: return "R4 R7";
      3: return "R5 R7";
      4: return "R6 R7";
      5, 6: return "R8";
      7: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pack_pair(input logic xe, input logic [1:0] x,
                                           input logic ye, input logic [1:0] y);
    return {xe, x, ye, y};
  endfunction

  task automatic run_row(input int r);
    row_t        row;
    logic [5:0]  exp_pair [16];
    int          nsym, s_idx, got, cyc;
    bit          pend;
    logic [5:0]  saved;
    row  = ROWS[r];
    nsym = 0;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] ex, ey;
      ex = '0; ey = '0;
      if (k < int'(row.npairs)) begin
        if (!row.xe[k]) begin ex = 2'(nsym % 4); nsym++; end
        if (!row.ye[k]) begin ey = 2'(nsym % 4); nsym++; end
      end
      exp_pair[k] = pack_pair(row.xe[k], ex, row.ye[k], ey);
    end
    s_idx = 0; got = 0; cyc = 0; pend = 1'b0; saved = '0;
    while (got < int'(row.npairs) && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (pend)
        chk(out_valid && pack_pair(out_x_erase, out_x, out_y_erase, out_y) == saved,
            "R10 stalled pair held", {26'd0, pack_pair(out_x_erase, out_x, out_y_erase, out_y)}, {26'd0, saved});
      rate_sel  = row.rate;
      in_valid  = (s_idx < nsym) && !(row.mode == 2'd1 && (cyc % 3) == 0);
      in_sym    = 2'(s_idx % 4);
      out_ready = (row.mode == 2'd2) ? ((cyc % 3) == 0) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        chk(pack_pair(out_x_erase, out_x, out_y_erase, out_y) == exp_pair[got],
            $sformatf("%s row %0d pair %0d", row_req(r), r, got),
            {26'd0, pack_pair(out_x_erase, out_x, out_y_erase, out_y)}, {26'd0, exp_pair[got]});
        got++;
      end
      if (in_valid && in_ready) s_idx++;
      pend  = out_valid && !out_ready;
      saved = pack_pair(out_x_erase, out_x, out_y_erase, out_y);
    end
    chk(got == int'(row.npairs), $sformatf("%s row %0d pair count", row_req(r), r), got, row.npairs);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready at rate 1/2", in_ready, 1);

    for (int r = 0; r < NROWS; r++) run_row(r);

    // R9: rate change arriving with the pair-completing symbol
    @(negedge clk);
    rate_sel = 3'd0; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);            // reload to 1/2 if needed
    @(negedge clk);
    in_valid = 1'b1; in_sym = 2'd2;
    #1;
    chk(in_ready == 1'b1, "R9 X accepted", in_ready, 1);
    @(negedge clk);
    rate_sel = 3'd2; in_sym = 2'd3;
    #1;
    chk(in_ready == 1'b1, "R9 mid-pair completes", in_ready, 1);
    @(negedge clk);
    in_sym = 2'd1;
    #1;
    chk(out_valid && pack_pair(out_x_erase, out_x, out_y_erase, out_y) == pack_pair(0, 2, 0, 3),
        "R9 old-rate pair", {26'd0, pack_pair(out_x_erase, out_x, out_y_erase, out_y)}, {26'd0, pack_pair(0, 2, 0, 3)});
    chk(in_ready == 1'b0, "R9 reload cycle", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R9 ready after reload", in_ready, 1);
    run_row(2);                // new rate starts at phase 0

    // R10: drain and refill in one cycle
    @(negedge clk);
    rate_sel = 3'd0;
    @(negedge clk);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_sym = 2'd1;
    @(negedge clk);
    in_sym = 2'd2;
    @(negedge clk);
    in_sym = 2'd3;
    #1;
    chk(out_valid && out_x == 2'd1 && out_y == 2'd2, "R10 first pair", {30'd0, out_x}, 1);
    @(negedge clk);
    in_sym = 2'd0;
    #1;
    chk(in_ready == 1'b0, "R10 blocked while full", in_ready, 0);
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0 && out_x == 2'd1 && out_y == 2'd2, "R10 still blocked and held", in_ready, 0);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 ready on drain", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && pack_pair(out_x_erase, out_x, out_y_erase, out_y) == pack_pair(0, 3, 0, 0),
        "R10 refilled pair", {26'd0, pack_pair(out_x_erase, out_x, out_y_erase, out_y)}, {26'd0, pack_pair(0, 3, 0, 0)});
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 drained", out_valid, 0);

    finish_run();
  end

endmodule